// File: doc/BRIEF.md
# Flow-Control Frame Detector

This block watches a byte-wide receive stream and picks out MAC control frames that ask the link partner to pause. It understands two kinds: the single-timer kind (one 16-bit quanta value that covers all traffic) and the per-class kind (an 8-bit class mask plus eight 16-bit timers). The stream reaches the block with the preamble and start delimiter already removed. Each byte carries a valid qualifier, and frames are marked with start and end flags. At the last byte, a good flag says whether the frame's CRC passed.

The fields are gathered as the bytes arrive. One cycle after the end of a frame, the block decides whether the frame was an acceptable pause request. If it was, it raises a one-cycle detection pulse and loads registered result outputs. These outputs then hold until the next accepted request. Three configuration checks gate acceptance: the destination address must match, the per-class receive enables apply to per-class frames, and a pair of enables applies to single-timer frames. The timers that act on these results, and the CRC check itself, live outside this block.

Top module: `pause_frame_detector`

## Requirements
- R1: While reset is high and after reset, `pause_det`, `pause_is_pfc`, `pause_quanta`, `pause_class_en` and `pause_class_time` are all zero.
- R2: A frame is accepted as a single-timer request when all of the following hold:
  - byte positions 0..5 hold destination 01-80-C2-00-00-01 (0x01 first on the wire);
  - positions 12..13 hold 0x8808;
  - positions 14..15 hold opcode 0x0001;
  - it has at least 18 bytes.

  The quanta value is at positions 16..17, high byte first. On acceptance, `pause_det` is 1 for exactly one cycle, two rising edges after the edge that takes the end-of-frame byte (that edge counted as the first). In the same cycle, `pause_is_pfc`=0, `pause_quanta` equals the received quanta, and `pause_class_en` and `pause_class_time` are zero.
- R3: A single-timer request is accepted only when both `cfg_std_rx_en` and `cfg_std_xoff_en` are 1.
- R4: The destination must equal either the control multicast address or `cfg_station_addr`. `cfg_station_addr`[47:40] is the first destination byte on the wire. Any other destination gives no detection.
- R5: A length/type value at positions 12..13 other than 0x8808 gives no detection.
- R6: Opcode 0x0101 at positions 14..15 selects a per-class request with at least 34 bytes. Positions 16..17 hold the class field, high byte first, and only its low 8 bits are used (bit n = class n). TIMEn sits at positions 18+2n..19+2n, high byte first. On acceptance:
  - `pause_is_pfc`=1 and `pause_quanta`=0;
  - `pause_class_en` equals the class field ANDed with `cfg_class_rx_en`;
  - `pause_class_time`[16n+15:16n] holds TIMEn where `pause_class_en`[n] is 1, and zero elsewhere.
- R7: A per-class request whose class field ANDed with `cfg_class_rx_en` is zero gives no detection.
- R8: A frame ending with `rx_good`=0 gives no detection. Outputs other than the pulse keep their previous values.
- R9: A frame that ends before all its required fields arrive gives no detection: fewer than 18 bytes for single-timer, fewer than 34 for per-class.
- R10: Any opcode other than 0x0001 and 0x0101 gives no detection, and all outputs keep their previous values.
- R11: Valid bytes that arrive outside a frame (no start flag since the last end) are ignored, even when they carry an end flag and a pause pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Byte qualifier |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_good | input | 1 | CRC passed, sampled with the last byte |
| rx_data | input | 8 | Receive byte |
| cfg_station_addr | input | 48 | Own unicast address, first wire byte in bits 47:40 |
| cfg_class_rx_en | input | 8 | Per-class receive pause enables |
| cfg_std_rx_en | input | 1 | Single-timer receive pause enable |
| cfg_std_xoff_en | input | 1 | Single-timer XOFF enable (bit 0 of that setting) |
| pause_det | output | 1 | One-cycle detection pulse |
| pause_is_pfc | output | 1 | 1 = per-class request, 0 = single-timer |
| pause_quanta | output | 16 | Single-timer quanta |
| pause_class_en | output | 8 | Accepted class mask |
| pause_class_time | output | 128 | Eight 16-bit class timers, class n at bits 16n+15:16n |

## Verification
The assertions assume that configuration inputs stay steady from the end-of-frame byte until the result is loaded. They also assume that `rx_good` matters only on the end-of-frame byte. The stimulus changes configuration only between frames, after the result has been sampled, and keeps `rx_good` low on every other byte. Frames are separated by at least one idle cycle, so two end-of-frame bytes never fall on neighbouring cycles. The one exception is the out-of-frame case, and that case is expected to be ignored.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    localparam int N_CLASS   = 8;
    localparam int QW        = 16;
    localparam int OCTET     = 8;
    localparam int ADDR_W    = 48;

    localparam int POS_TIME0_I = 18;
    localparam int LEN_STD_I   = 18;
    localparam int LEN_PFC_I   = POS_TIME0_I + 2 * N_CLASS;
    localparam int POS_W       = $clog2(LEN_PFC_I + 1);

    typedef logic [POS_W-1:0] pos_t;

    localparam pos_t P_SA     = pos_t'(6);
    localparam pos_t P_TYPE   = pos_t'(12);
    localparam pos_t P_OP     = pos_t'(14);
    localparam pos_t P_ARG    = pos_t'(16);
    localparam pos_t P_TIME0  = pos_t'(POS_TIME0_I);
    localparam pos_t LEN_STD  = pos_t'(LEN_STD_I);
    localparam pos_t LEN_PFC  = pos_t'(LEN_PFC_I);
    localparam pos_t POS_MAX  = '1;

    localparam logic [ADDR_W-1:0] CTRL_MCAST = 48'h0180_C200_0001;
    localparam logic [QW-1:0]     ETYPE_CTRL = 16'h8808;
    localparam logic [QW-1:0]     OP_STD     = 16'h0001;
    localparam logic [QW-1:0]     OP_PFC     = 16'h0101;

    typedef struct packed {
        logic [ADDR_W-1:0] da;
        logic [QW-1:0]     etype;
        logic [QW-1:0]     opcode;
        logic [QW-1:0]     arg;
    } hdr_t;

    typedef enum logic {
        KIND_STD = 1'b0,
        KIND_PFC = 1'b1
    } pause_kind_t;

    function automatic logic [QW-1:0] push8(logic [QW-1:0] v, logic [OCTET-1:0] b);
        return {v[QW-OCTET-1:0], b};
    endfunction

    function automatic logic in_pair(pos_t p, pos_t base);
        return (p == base) || (p == pos_t'(base + 1'b1));
    endfunction

endpackage

// File: rtl/pfd_capture.sv
module pfd_capture
    import pfd_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         in_valid,
    input  logic                         in_sof,
    input  logic                         in_eof,
    input  logic                         in_good,
    input  logic [OCTET-1:0]             in_data,
    output hdr_t                         hdr,
    output logic [N_CLASS-1:0][QW-1:0]   times,
    output pos_t                         nbytes,
    output logic                         frame_end
);

    pos_t cnt;
    pos_t pos;
    pos_t pos_inc;
    logic in_frame;
    logic take;

    assign pos     = in_sof ? '0 : cnt;
    assign take    = in_valid && (in_sof || in_frame);
    assign pos_inc = (pos == POS_MAX) ? pos : pos + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            in_frame  <= 1'b0;
            nbytes    <= '0;
            frame_end <= 1'b0;
            hdr       <= '0;
        end else begin
            frame_end <= take && in_eof && in_good;
            if (take) begin
                cnt      <= pos_inc;
                in_frame <= !in_eof;
                if (in_eof)
                    nbytes <= pos_inc;
                if (pos < P_SA)
                    hdr.da <= {hdr.da[ADDR_W-OCTET-1:0], in_data};
                if (in_pair(pos, P_TYPE))
                    hdr.etype <= push8(hdr.etype, in_data);
                if (in_pair(pos, P_OP))
                    hdr.opcode <= push8(hdr.opcode, in_data);
                if (in_pair(pos, P_ARG))
                    hdr.arg <= push8(hdr.arg, in_data);
            end
        end
    end

    for (genvar g = 0; g < N_CLASS; g++) begin : g_time
        localparam pos_t P_T = pos_t'(POS_TIME0_I + 2 * g);
        logic [QW-1:0] t_q;
        always_ff @(posedge clk) begin
            if (rst)
                t_q <= '0;
            else if (take && in_pair(pos, P_T))
                t_q <= push8(t_q, in_data);
        end
        assign times[g] = t_q;
    end

    assert_eof_latency_R2: assert property (@(posedge clk) disable iff (rst)
        frame_end |-> $past(in_valid && in_eof && in_good));

endmodule

// File: rtl/pfd_judge.sv
module pfd_judge
    import pfd_pkg::*;
(
    input  hdr_t                         hdr,
    input  logic [N_CLASS-1:0][QW-1:0]   times,
    input  pos_t                         nbytes,
    input  logic                         frame_end,
    input  logic [ADDR_W-1:0]            station_addr,
    input  logic [N_CLASS-1:0]           class_rx_en,
    input  logic                         std_rx_en,
    input  logic                         std_xoff_en,
    output logic                         hit,
    output pause_kind_t                  kind,
    output logic [QW-1:0]                quanta,
    output logic [N_CLASS-1:0]           class_en,
    output logic [N_CLASS-1:0][QW-1:0]   class_time
);

    logic da_ok;
    logic hdr_ok;
    logic std_hit;
    logic pfc_hit;
    logic [N_CLASS-1:0] mask;

    assign da_ok   = (hdr.da == CTRL_MCAST) || (hdr.da == station_addr);
    assign hdr_ok  = frame_end && da_ok && (hdr.etype == ETYPE_CTRL);
    assign mask    = hdr.arg[N_CLASS-1:0] & class_rx_en;

    assign std_hit = hdr_ok && (hdr.opcode == OP_STD) && (nbytes >= LEN_STD)
                     && std_rx_en && std_xoff_en;
    assign pfc_hit = hdr_ok && (hdr.opcode == OP_PFC) && (nbytes >= LEN_PFC)
                     && (mask != '0);

    assign hit      = std_hit || pfc_hit;
    assign kind     = pfc_hit ? KIND_PFC : KIND_STD;
    assign quanta   = pfc_hit ? '0 : hdr.arg;
    assign class_en = pfc_hit ? mask : '0;

    for (genvar g = 0; g < N_CLASS; g++) begin : g_sel
        assign class_time[g] = class_en[g] ? times[g] : '0;
    end

endmodule

// File: rtl/pause_frame_detector.sv
module pause_frame_detector
    import pfd_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      rx_valid,
    input  logic                      rx_sof,
    input  logic                      rx_eof,
    input  logic                      rx_good,
    input  logic [7:0]                rx_data,
    input  logic [47:0]               cfg_station_addr,
    input  logic [7:0]                cfg_class_rx_en,
    input  logic                      cfg_std_rx_en,
    input  logic                      cfg_std_xoff_en,
    output logic                      pause_det,
    output logic                      pause_is_pfc,
    output logic [15:0]               pause_quanta,
    output logic [7:0]                pause_class_en,
    output logic [127:0]              pause_class_time
);

    localparam int TIME_W = N_CLASS * QW;

    hdr_t                       c_hdr;
    logic [N_CLASS-1:0][QW-1:0] c_times;
    pos_t                       c_nbytes;
    logic                       c_end;

    logic                       j_hit;
    pause_kind_t                j_kind;
    logic [QW-1:0]              j_quanta;
    logic [N_CLASS-1:0]         j_en;
    logic [N_CLASS-1:0][QW-1:0] j_time;

    pfd_capture u_capture (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (rx_valid),
        .in_sof    (rx_sof),
        .in_eof    (rx_eof),
        .in_good   (rx_good),
        .in_data   (rx_data),
        .hdr       (c_hdr),
        .times     (c_times),
        .nbytes    (c_nbytes),
        .frame_end (c_end)
    );

    pfd_judge u_judge (
        .hdr          (c_hdr),
        .times        (c_times),
        .nbytes       (c_nbytes),
        .frame_end    (c_end),
        .station_addr (cfg_station_addr),
        .class_rx_en  (cfg_class_rx_en),
        .std_rx_en    (cfg_std_rx_en),
        .std_xoff_en  (cfg_std_xoff_en),
        .hit          (j_hit),
        .kind         (j_kind),
        .quanta       (j_quanta),
        .class_en     (j_en),
        .class_time   (j_time)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pause_det        <= 1'b0;
            pause_is_pfc     <= 1'b0;
            pause_quanta     <= '0;
            pause_class_en   <= '0;
            pause_class_time <= '0;
        end else begin
            pause_det <= j_hit;
            if (j_hit) begin
                pause_is_pfc     <= (j_kind == KIND_PFC);
                pause_quanta     <= j_quanta;
                pause_class_en   <= j_en;
                pause_class_time <= TIME_W'(j_time);
            end
        end
    end

    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        pause_det |=> !pause_det);

    assert_std_clear_R2: assert property (@(posedge clk) disable iff (rst)
        (pause_det && !pause_is_pfc) |-> (pause_class_en == '0 && pause_class_time == '0));

    assert_class_mask_R6: assert property (@(posedge clk) disable iff (rst)
        (pause_det && pause_is_pfc) |-> ((pause_class_en & ~$past(cfg_class_rx_en)) == '0));

    assert_nonempty_R7: assert property (@(posedge clk) disable iff (rst)
        (pause_det && pause_is_pfc) |-> (pause_class_en != '0 && pause_quanta == '0));

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !c_end |=> ($stable(pause_quanta) && $stable(pause_class_en)
                    && $stable(pause_class_time) && !pause_det));

endmodule

// File: tb/tb_pause_frame_detector.sv
`timescale 1ns/1ps
module tb_pause_frame_detector;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic         rst;
    logic         rx_valid, rx_sof, rx_eof, rx_good;
    logic [7:0]   rx_data;
    logic [47:0]  cfg_station_addr;
    logic [7:0]   cfg_class_rx_en;
    logic         cfg_std_rx_en, cfg_std_xoff_en;
    logic         pause_det, pause_is_pfc;
    logic [15:0]  pause_quanta;
    logic [7:0]   pause_class_en;
    logic [127:0] pause_class_time;

    pause_frame_detector dut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .rx_good(rx_good), .rx_data(rx_data), .cfg_station_addr(cfg_station_addr),
        .cfg_class_rx_en(cfg_class_rx_en), .cfg_std_rx_en(cfg_std_rx_en),
        .cfg_std_xoff_en(cfg_std_xoff_en), .pause_det(pause_det), .pause_is_pfc(pause_is_pfc),
        .pause_quanta(pause_quanta), .pause_class_en(pause_class_en),
        .pause_class_time(pause_class_time)
    );

    localparam logic [47:0] MC = 48'h0180C2000001;
    localparam logic [47:0] ST = 48'h02AB_CD12_3456;

    int total = 0;
    int bad = 0;

    logic [47:0]  f_da;
    logic [15:0]  f_type, f_op, f_arg;
    logic [15:0]  f_t [8];

    logic         m_pfc;
    logic [15:0]  m_q;
    logic [7:0]   m_en;
    logic [127:0] m_t;

    function automatic logic [7:0] fb(int p);
        if (p < 6)  return f_da[47 - 8*p -: 8];
        if (p < 12) return 8'(8'h20 + p);
        if (p == 12) return f_type[15:8];
        if (p == 13) return f_type[7:0];
        if (p == 14) return f_op[15:8];
        if (p == 15) return f_op[7:0];
        if (p == 16) return f_arg[15:8];
        if (p == 17) return f_arg[7:0];
        if (p < 34) return ((p % 2) == 0) ? f_t[(p-18)/2][15:8] : f_t[(p-18)/2][7:0];
        return 8'(p) ^ 8'h5A;
    endfunction

    task automatic set_times(int seed);
        for (int n = 0; n < 8; n++) f_t[n] = 16'(seed * 257 + n * 4099 + 1);
    endtask

    task automatic check(logic ok, string tag, logic [127:0] act, logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(int len, logic g, logic with_sof);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_sof   = with_sof && (i == 0);
            rx_eof   = (i == len - 1);
            rx_good  = (i == len - 1) ? g : 1'b0;
            rx_data  = fb(i);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_good = 1'b0; rx_data = 8'h00;
    endtask

    task automatic frame(int len, logic g, logic with_sof, string tag);
        logic da_ok, hdr, hit, e_pfc;
        logic [7:0] msk;
        logic [15:0] e_q;
        logic [127:0] e_t;
        da_ok = (f_da == MC) || (f_da == cfg_station_addr);
        hdr   = with_sof && g && da_ok && (f_type == 16'h8808);
        msk   = f_arg[7:0] & cfg_class_rx_en;
        hit = 1'b0; e_pfc = 1'b0; e_q = 16'h0; e_t = '0;
        if (f_op == 16'h0001) begin
            hit = hdr && len >= 18 && cfg_std_rx_en && cfg_std_xoff_en;
            e_q = f_arg; msk = 8'h00;
        end else if (f_op == 16'h0101) begin
            hit = hdr && len >= 34 && msk != 8'h00;
            e_pfc = 1'b1;
            for (int n = 0; n < 8; n++) if (msk[n]) e_t[16*n +: 16] = f_t[n];
        end
        if (hit) begin
            m_pfc = e_pfc; m_q = e_q; m_en = msk; m_t = e_t;
        end
        send(len, g, with_sof);
        @(negedge clk);
        check(pause_det == hit, {tag, " det"}, 128'(pause_det), 128'(hit));
        check(pause_is_pfc == m_pfc && pause_quanta == m_q && pause_class_en == m_en,
              {tag, " fields"}, {pause_is_pfc, pause_quanta, pause_class_en},
              {m_pfc, m_q, m_en});
        check(pause_class_time == m_t, {tag, " times"}, pause_class_time, m_t);
        @(negedge clk);
        check(pause_det == 1'b0, {tag, " R2 pulse width"}, 128'(pause_det), 128'(0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_good = 0; rx_data = 0;
        cfg_station_addr = ST; cfg_class_rx_en = 8'hFF;
        cfg_std_rx_en = 1'b1; cfg_std_xoff_en = 1'b1;
        m_pfc = 0; m_q = 0; m_en = 0; m_t = '0;
        set_times(3);
        repeat (4) @(negedge clk);
        check(pause_det == 0 && pause_is_pfc == 0 && pause_quanta == 0 && pause_class_en == 0
              && pause_class_time == 0, "R1 during reset", pause_class_time, '0);
        rst = 1'b0;
        @(negedge clk);
        check(pause_det == 0 && pause_quanta == 0 && pause_class_time == 0,
              "R1 after reset", 128'(pause_quanta), '0);

        // R2: single-timer quanta sweep
        f_da = MC; f_type = 16'h8808; f_op = 16'h0001;
        for (int i = 0; i < 20; i++) begin
            f_arg = (i < 4) ? 16'(16'h00FF << (4*i)) : 16'(i * 16'h1357 + 16'hFFFF * (i % 2));
            frame(60, 1'b1, 1'b1, "R2 quanta sweep");
        end

        // R3: enable combinations
        for (int c = 0; c < 4; c++) begin
            cfg_std_rx_en = c[0]; cfg_std_xoff_en = c[1];
            f_arg = 16'(16'h4000 + c);
            frame(60, 1'b1, 1'b1, "R3 std enables");
        end
        cfg_std_rx_en = 1'b1; cfg_std_xoff_en = 1'b1;

        // R4: station address accepted, single-bit destination errors rejected
        f_da = ST; f_arg = 16'h1234;
        frame(60, 1'b1, 1'b1, "R4 station address");
        for (int b = 0; b < 48; b++) begin
            f_da = MC ^ (48'h1 << b);
            f_arg = 16'(b + 100);
            frame(20, 1'b1, 1'b1, "R4 address mismatch");
        end
        f_da = MC;

        // R5: type mismatch
        for (int b = 0; b < 16; b++) begin
            f_type = 16'h8808 ^ (16'h1 << b);
            frame(20, 1'b1, 1'b1, "R5 type mismatch");
        end
        f_type = 16'h8808;

        // R6: class field sweep, upper byte ignored
        f_op = 16'h0101;
        cfg_class_rx_en = 8'hA7;
        for (int v = 0; v < 256; v++) begin
            f_arg = {8'(v ^ 8'h3C), 8'(v)};
            set_times(v);
            frame(34 + (v % 30), 1'b1, 1'b1, "R6 R7 class field sweep");
        end
        // R6/R7: enable sweep
        f_arg = 16'h00FF;
        for (int v = 0; v < 256; v++) begin
            cfg_class_rx_en = 8'(v);
            set_times(v + 7);
            frame(40, 1'b1, 1'b1, "R6 R7 enable sweep");
        end
        cfg_class_rx_en = 8'hFF;

        // R8: bad CRC flag
        f_arg = 16'h00F0; set_times(91);
        frame(60, 1'b0, 1'b1, "R8 bad frame pfc");
        f_op = 16'h0001; f_arg = 16'hBEEF;
        frame(60, 1'b0, 1'b1, "R8 bad frame std");

        // R9: truncation boundaries
        for (int l = 1; l <= 18; l++) begin
            f_arg = 16'(16'h0500 + l);
            frame(l, 1'b1, 1'b1, "R9 std length");
        end
        f_op = 16'h0101; f_arg = 16'h0055;
        for (int l = 17; l <= 34; l++) begin
            set_times(l);
            frame(l, 1'b1, 1'b1, "R9 pfc length");
        end

        // R10: other opcodes
        for (int b = 0; b < 16; b++) begin
            f_op = 16'h0001 ^ (16'h1 << b);
            f_arg = 16'(16'h7700 + b);
            set_times(200 + b);
            frame(40, 1'b1, 1'b1, "R10 opcode");
        end

        // R11: bytes outside a frame
        f_op = 16'h0001; f_arg = 16'h2222;
        frame(40, 1'b1, 1'b0, "R11 no start flag");
        f_op = 16'h0101; f_arg = 16'h00FF; set_times(5);
        frame(40, 1'b1, 1'b0, "R11 no start flag pfc");
        frame(40, 1'b1, 1'b1, "R11 framed again");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule